// File: doc/BRIEF.md
# Event-Driven PWM Action Generator

This block makes one pulse-width-modulated output from a free-running counter and two comparators. The counter runs in one of two shapes. In count-down mode it falls from a programmable period value to zero and then reloads. In count-up/down mode it climbs from zero to the period value and falls back again. Six counter events can change the output: reaching zero, reaching the period value, and a match on comparator A or comparator B. Each compare match is split by the direction in which the counter is moving.

Each event has its own 2-bit action field in a 12-bit control word. The action keeps, inverts, clears or sets the registered output. When several events fall in the same cycle, one fixed priority picks the single action that is applied. With these fields, software can place both edges of a pulse anywhere in the period and get edge-aligned or centre-aligned waveforms. While the enable input is low, the counter and the output are parked.

Top module: `pwm_action_gen`

## Requirements
- R1: While `enable` is low the counter is held at 0, no event is produced, and `pwmOut` is 0 from the next clock edge on.
- R2: In count-down mode (`upDownMode`=0) the counter steps down by one each cycle. From 0 it reloads `loadVal`, so the period is `loadVal`+1 cycles. After enable rises the first counted value is 0.
- R3: In count-up/down mode (`upDownMode`=1) the counter steps 0,1,...,`loadVal`,`loadVal`-1,...,1,0 and repeats, so the period is 2×`loadVal` cycles.
- R4: Action encoding: 2'b00 keeps the output, 2'b01 inverts it, 2'b10 drives it low and 2'b11 drives it high. A cycle with no event keeps the output.
- R5: Field positions in `actionCtrl`: [1:0] zero, [3:2] load, [5:4] compare A up, [7:6] compare A down, [9:8] compare B up, [11:10] compare B down. A compare match is "up" only in count-up/down mode while the counter rises; it is "down" otherwise.
- R6: In count-down mode the two compare-up fields never affect the output.
- R7: When a zero or load event falls in the same cycle as a compare match, the zero or load field is applied and the compare field is discarded. This holds even when that field is 2'b00.
- R8: When compare A and compare B match in the same cycle, only the compare A field is applied.
- R9: When `loadVal` is 0, zero and load coincide every cycle and the zero field is applied.
- R10: `pwmOut` is a register. The action picked from the counter value of one cycle appears on `pwmOut` after the following clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the counter and the output when high |
| upDownMode | input | 1 | 0 selects count-down, 1 selects count-up/down |
| actionCtrl | input | 12 | Six 2-bit action fields |
| loadVal | input | CNT_W | Period value of the counter |
| cmpA | input | CNT_W | Comparator A value |
| cmpB | input | CNT_W | Comparator B value |
| pwmOut | output | 1 | Registered PWM output |

## Verification
The checker watches several rules on every cycle: that no events appear while disabled, that the output parks low, that the compare-up events stay silent in count-down mode, that an all-keep control word freezes the output, and that the zero, load and compare A priorities are honoured whenever they coincide. Other properties show only over whole periods, so only the bench's directed scenarios can reveal them. These are the exact counter shapes in both modes, the placement of each action field in the control word, and waveforms where compare values sit on zero or on the period value. Those scenarios run an independent cycle model beside the design and compare the output every cycle.

// File: rtl/pwm_action_pkg.sv
package pwm_action_pkg;

  localparam int NUM_EVT  = 6;
  localparam int ACT_W    = 2;
  localparam int CTRL_W   = NUM_EVT * ACT_W;

  // field index order inside the control word (decoded by position)
  localparam int F_ZERO   = 0;
  localparam int F_LOAD   = 1;
  localparam int F_AUP    = 2;
  localparam int F_ADOWN  = 3;
  localparam int F_BUP    = 4;
  localparam int F_BDOWN  = 5;

  typedef enum logic [ACT_W-1:0] {
    ACT_KEEP = 2'b00,
    ACT_FLIP = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIGH = 2'b11
  } act_e;

  // strobes from the counter datapath to the action control
  typedef struct packed {
    logic atZero;
    logic atLoad;
    logic aUp;
    logic aDown;
    logic bUp;
    logic bDown;
  } evt_t;

  function automatic act_e fieldOf(input logic [CTRL_W-1:0] word, input int idx);
    return act_e'(word[idx*ACT_W +: ACT_W]);
  endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_action_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             upDownMode,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  output evt_t             evt
);

  localparam int NUM_CMP = 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             goingDown;
  logic [CNT_W-1:0] cntNext;
  logic             goingDownNext;

  // counter shape
  always_comb begin
    cntNext       = cnt;
    goingDownNext = goingDown;
    if (!upDownMode) begin
      goingDownNext = 1'b0;
      cntNext       = (cnt == '0) ? loadVal : cnt - ONE;
    end else if (!goingDown) begin
      if (cnt >= loadVal) begin
        goingDownNext = 1'b1;
        cntNext       = (cnt == '0) ? '0 : cnt - ONE;
      end else begin
        cntNext = cnt + ONE;
      end
    end else begin
      if (cnt == '0) begin
        goingDownNext = 1'b0;
        cntNext       = (loadVal == '0) ? '0 : ONE;
      end else begin
        cntNext = cnt - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      goingDown <= 1'b0;
    end else if (!enable) begin
      cnt       <= '0;
      goingDown <= 1'b0;
    end else begin
      cnt       <= cntNext;
      goingDown <= goingDownNext;
    end
  end

  // comparators, one per compare value
  logic [CNT_W-1:0] cmpVal [NUM_CMP];
  logic [NUM_CMP-1:0] hitUp;
  logic [NUM_CMP-1:0] hitDown;
  logic risingNow;

  assign cmpVal[0] = cmpA;
  assign cmpVal[1] = cmpB;
  assign risingNow = upDownMode && !goingDown;

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    logic match;
    assign match      = enable && (cnt == cmpVal[c]);
    assign hitUp[c]   = match && risingNow;
    assign hitDown[c] = match && !risingNow;
  end

  always_comb begin
    evt.atZero = enable && (cnt == '0);
    evt.atLoad = enable && (cnt == loadVal);
    evt.aUp    = hitUp[0];
    evt.aDown  = hitDown[0];
    evt.bUp    = hitUp[1];
    evt.bDown  = hitDown[1];
  end

endmodule

// File: rtl/pwm_action_ctrl.sv
module pwm_action_ctrl
  import pwm_action_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CTRL_W-1:0] actionCtrl,
  input  evt_t              evt,
  output logic              pwmOut
);

  act_e chosen;
  logic outNext;

  // fixed priority: zero, load, A up, A down, B up, B down
  always_comb begin
    chosen = ACT_KEEP;
    if      (evt.atZero) chosen = fieldOf(actionCtrl, F_ZERO);
    else if (evt.atLoad) chosen = fieldOf(actionCtrl, F_LOAD);
    else if (evt.aUp)    chosen = fieldOf(actionCtrl, F_AUP);
    else if (evt.aDown)  chosen = fieldOf(actionCtrl, F_ADOWN);
    else if (evt.bUp)    chosen = fieldOf(actionCtrl, F_BUP);
    else if (evt.bDown)  chosen = fieldOf(actionCtrl, F_BDOWN);
  end

  always_comb begin
    unique case (chosen)
      ACT_FLIP: outNext = ~pwmOut;
      ACT_LOW:  outNext = 1'b0;
      ACT_HIGH: outNext = 1'b1;
      default:  outNext = pwmOut;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pwmOut <= 1'b0;
    else if (!enable) pwmOut <= 1'b0;
    else              pwmOut <= outNext;
  end

endmodule

// File: rtl/pwm_action_gen.sv
module pwm_action_gen
  import pwm_action_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             upDownMode,
  input  logic [11:0]      actionCtrl,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  output logic             pwmOut
);

  evt_t evt;

  pwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .upDownMode (upDownMode),
    .loadVal    (loadVal),
    .cmpA       (cmpA),
    .cmpB       (cmpB),
    .evt        (evt)
  );

  pwm_action_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .actionCtrl (actionCtrl),
    .evt        (evt),
    .pwmOut     (pwmOut)
  );

endmodule

// File: rtl/pwm_action_chk.sv
module pwm_action_chk
  import pwm_action_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        upDownMode,
  input logic [11:0] actionCtrl,
  input evt_t        evt,
  input logic        pwmOut
);

  AST_IDLE_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (evt == '0)) else $error("idle event"); // R1

  AST_IDLE_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pwmOut) else $error("idle output"); // R1

  AST_DOWN_NO_UP: assert property (@(posedge clk) disable iff (!rst_n)
    !upDownMode |-> (!evt.aUp && !evt.bUp)) else $error("up event in down mode"); // R6

  AST_ALL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && actionCtrl == 12'h000) |=> (pwmOut == $past(pwmOut))) else $error("keep"); // R4

  AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && evt.atZero && actionCtrl[1:0] == 2'b11) |=> pwmOut) else $error("zero prio"); // R7

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && evt.atLoad && !evt.atZero && actionCtrl[3:2] == 2'b10) |=> !pwmOut) else $error("load prio"); // R7

  AST_A_OVER_B: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && evt.aDown && !evt.atZero && !evt.atLoad && actionCtrl[7:6] == 2'b10)
      |=> !pwmOut) else $error("A over B"); // R8

endmodule

bind pwm_action_gen pwm_action_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .upDownMode (upDownMode),
  .actionCtrl (actionCtrl),
  .evt        (evt),
  .pwmOut     (pwmOut)
);

// File: tb/pwm_action_gen_bench.sv
`timescale 1ns/1ps
module pwm_action_gen_bench;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          upDownMode = 1'b0;
  logic [11:0]   actionCtrl = '0;
  logic [W-1:0]  loadVal = '0;
  logic [W-1:0]  cmpA = '0;
  logic [W-1:0]  cmpB = '0;
  logic          pwmOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwm_action_gen #(.CNT_W(W)) u_pwm_action_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .upDownMode(upDownMode),
    .actionCtrl(actionCtrl), .loadVal(loadVal), .cmpA(cmpA), .cmpB(cmpB),
    .pwmOut(pwmOut)
  );

  // independent cycle model built from the requirements
  logic [W-1:0] mCnt;
  logic         mFall;
  logic         mOut;

  always @(posedge clk or negedge rst_n) begin
    int pick;
    logic [1:0] act;
    logic rising;
    if (!rst_n) begin
      mCnt <= '0; mFall <= 1'b0; mOut <= 1'b0;
    end else if (!enable) begin
      mCnt <= '0; mFall <= 1'b0; mOut <= 1'b0;
    end else begin
      rising = upDownMode && !mFall;
      pick = -1;
      if (mCnt == 0)            pick = 0;
      else if (mCnt == loadVal) pick = 1;
      else if (mCnt == cmpA)    pick = rising ? 2 : 3;
      else if (mCnt == cmpB)    pick = rising ? 4 : 5;
      act = (pick < 0) ? 2'b00 : actionCtrl[2*pick +: 2];
      case (act)
        2'b01: mOut <= ~mOut;
        2'b10: mOut <= 1'b0;
        2'b11: mOut <= 1'b1;
        default: ;
      endcase
      if (!upDownMode) begin
        mFall <= 1'b0;
        mCnt  <= (mCnt == 0) ? loadVal : mCnt - 1'b1;
      end else if (!mFall) begin
        if (mCnt >= loadVal) begin
          mFall <= 1'b1;
          mCnt  <= (mCnt == 0) ? '0 : mCnt - 1'b1;
        end else mCnt <= mCnt + 1'b1;
      end else if (mCnt == 0) begin
        mFall <= 1'b0;
        mCnt  <= (loadVal == 0) ? '0 : W'(1);
      end else mCnt <= mCnt - 1'b1;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pwmOut=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // restart with a new configuration; returns at a falling edge with enable just raised
  task automatic startRun(input logic ud, input logic [11:0] ctrl,
                          input int ld, input int a, input int b);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    upDownMode = ud; actionCtrl = ctrl;
    loadVal = W'(ld); cmpA = W'(a); cmpB = W'(b);
    enable = 1'b1;
  endtask

  task automatic runCompare(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, pwmOut, mOut);
    end
  endtask

  task automatic t_reset_idle();
    chk("R1 reset", pwmOut, 1'b0);
    @(negedge clk);
    enable = 1'b0; actionCtrl = 12'hFFF; loadVal = W'(3);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R1 idle", pwmOut, 1'b0);
    end
  endtask

  task automatic t_latency();
    // zero action = high; enable raised at a falling edge, first edge sees count 0
    startRun(1'b0, 12'h003, 5, 9, 9);
    chk("R10 before edge", pwmOut, 1'b0);
    @(negedge clk);
    chk("R10 after edge", pwmOut, 1'b1);
    // drop enable: output low after the next edge
    enable = 1'b0;
    chk("R1 one cycle", pwmOut, 1'b1);
    @(negedge clk);
    chk("R1 parked", pwmOut, 1'b0);
  endtask

  task automatic t_down_toggle();
    // R2 R4: zero toggles, period load+1 => output period 2*(load+1)
    startRun(1'b0, 12'h001, 5, 9, 9);
    runCompare("R2 toggle", 40);
    // explicit: edge1 cnt0 ->1, edges2..6 cnt5..1 keep, edge7 cnt0 ->0
    startRun(1'b0, 12'h001, 5, 9, 9);
    repeat (6) @(negedge clk);
    chk("R2 mid period", pwmOut, 1'b1);
    @(negedge clk);
    chk("R2 reload", pwmOut, 1'b0);
  endtask

  task automatic t_encodings();
    // R4: set at zero, clear on A down, keep on B
    startRun(1'b0, 12'h0A3, 7, 3, 5);
    runCompare("R4 set/clear", 40);
    startRun(1'b0, 12'h000, 7, 3, 5);
    runCompare("R4 keep", 20);
    startRun(1'b1, 12'h6C1, 6, 2, 4);
    runCompare("R3 updown mixed", 60);
  endtask

  task automatic t_updown();
    // R3: load high, zero low => high for L cycles, low for L cycles
    startRun(1'b1, 12'h00E, 4, 9, 9);
    runCompare("R3 shape", 40);
    // edge1 cnt0 low; edges for cnt1..3 keep; edge5 cnt4 high
    startRun(1'b1, 12'h00E, 4, 9, 9);
    repeat (4) @(negedge clk);
    chk("R3 before top", pwmOut, 1'b0);
    @(negedge clk);
    chk("R3 at top", pwmOut, 1'b1);
    repeat (4) @(negedge clk);
    chk("R3 back at zero", pwmOut, 1'b0);
  endtask

  task automatic t_fields();
    for (int f = 0; f < 6; f++) begin
      bit sawHigh;
      sawHigh = 0;
      startRun(1'b1, 12'(2'b11) << (2*f), 8, 3, 5);
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        chk("R5 field", pwmOut, mOut);
        if (pwmOut) sawHigh = 1;
      end
      total++;
      if (!sawHigh) begin
        bad++;
        $display("FAIL R5 field %0d: sawHigh=0 expected=1", f);
      end
    end
  endtask

  task automatic t_down_ignores_up();
    startRun(1'b0, 12'h330, 8, 3, 5);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk("R6 up fields silent", pwmOut, 1'b0);
    end
  endtask

  task automatic t_priority();
    // R7: cmpA on zero, zero toggles, A down high -> output still alternates
    startRun(1'b0, 12'h0C1, 4, 0, 9);
    runCompare("R7 zero beats A", 30);
    startRun(1'b0, 12'h0C1, 4, 0, 9);
    repeat (6) @(negedge clk);
    chk("R7 second zero", pwmOut, 1'b0);
    // R7: cmpB on load with keep load action; B down high ignored
    startRun(1'b0, 12'hC00, 4, 9, 4);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk("R7 load keep beats B", pwmOut, 1'b0);
    end
    // R8: A==B, zero high, A down low, B down high
    startRun(1'b0, 12'hC83, 5, 3, 3);
    repeat (3) @(negedge clk);
    chk("R8 before match", pwmOut, 1'b1);
    @(negedge clk);
    chk("R8 A wins", pwmOut, 1'b0);
    runCompare("R8 run", 20);
  endtask

  task automatic t_load_zero();
    // R9: load 0 -> zero (toggle) beats load (high) every cycle
    startRun(1'b0, 12'h00D, 0, 0, 0);
    @(negedge clk);
    chk("R9 first", pwmOut, 1'b1);
    @(negedge clk);
    chk("R9 second", pwmOut, 1'b0);
    runCompare("R9 down", 10);
    startRun(1'b1, 12'h00D, 0, 0, 0);
    runCompare("R9 updown", 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_latency();
    t_down_toggle();
    t_encodings();
    t_updown();
    t_fields();
    t_down_ignores_up();
    t_priority();
    t_load_zero();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule